// File: doc/BRIEF.md
# Processor Reset Sequencer

This block turns an external active-high reset pin into an orderly start of a processor core. The pin is asynchronous to the core clock. It is first brought into the clock domain through a two-flop synchronizer, then qualified by width. A pulse must stay high for more than four clocks to count as a reset. Shorter pulses are discarded, and the core keeps running.

Once the pin is accepted, the core is halted and stays halted for as long as the pin remains high. When the pin drops, the block runs an internal initialization interval of exactly ten clocks. It then issues a single-cycle start pulse and releases the core. The core makes its first fetch from the physical address `FFFF0h`, which the block presents on its start-address output.

If the pin rises again while the initialization interval is counting, the count is abandoned. The block falls back into the halted state and starts a fresh ten-clock interval only after the pin drops again. All outputs are plain control levels; there is no data stream and no handshake.

Top module: `core_start_sequencer`

## Requirements
- R1: When `rst_pin` is high at five or more consecutive rising clock edges, `core_halt` goes high. Counting the first edge that samples the pin high as edge 0, `core_halt` is first high after edge 6.
- R2: A high pulse on `rst_pin` seen at four or fewer consecutive edges is ignored. `core_halt`, `init_busy` and `start_pulse` all stay low, and the core keeps running.
- R3: Once `core_halt` is high, it remains high for as long as `rst_pin` stays high, however long that lasts. It falls only in the cycle in which `start_pulse` is high.
- R4: Counting the first edge that samples the pin low as edge 0, `init_busy` is high after edges 2 through 11, which is exactly ten cycles. `core_halt` stays high during all of them.
- R5: `start_pulse` is high for exactly one cycle, after edge 12, which is the cycle right after `init_busy` falls. In that same cycle `core_halt` is low.
- R6: Whenever `start_pulse` is high, `start_addr` equals 20'hFFFF0.
- R7: If `rst_pin` is sampled high during the initialization interval, even for a single edge and even on the interval's last edge, the interval is abandoned. `init_busy` drops, `core_halt` stays high, and no start pulse is issued. After the pin is low again, a full ten-cycle interval runs before the start pulse.
- R8: After the start pulse, `core_halt` stays low while `rst_pin` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_pin | input | 1 | External reset pin, active high, asynchronous to `clk` |
| core_halt | output | 1 | Core must stay dormant while high |
| init_busy | output | 1 | High while the internal initialization interval runs |
| start_pulse | output | 1 | One-cycle strobe that releases the core |
| start_addr | output | 20 | Physical address of the first fetch |

## Verification
Two events can land on the same edge: the last count of the initialization interval and a renewed rise of the reset pin. The completion of the count would issue the start pulse, while the new reset would abort the interval. The bench provokes this by driving the pin high for a single clock, timed so that its synchronized copy reaches the state machine on the very edge where the interval would end. It then judges the outcome at the ports. No start pulse may appear, `core_halt` must stay high, `init_busy` must drop, and a fresh ten-cycle interval followed by exactly one start pulse must follow once the pin is low.

// File: rtl/rsq_pkg.sv
package rsq_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_HALT  = 2'd1,
    ST_INIT  = 2'd2,
    ST_START = 2'd3
  } seq_state_e;
endpackage

// File: rtl/rsq_sync.sv
// Multi-flop synchronizer bringing the asynchronous pin into the clk domain.
module rsq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/rsq_width_qual.sv
// Counts consecutive high samples; flags the sample that makes the pulse long enough.
module rsq_width_qual #(
  parameter int MIN_HIGH = 4
) (
  input  logic clk,
  input  logic lvl,
  output logic long_high
);
  localparam int CW = $clog2(MIN_HIGH + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(MIN_HIGH);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!lvl)                cnt <= '0;
    else if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
  end

  // The sample that finds the count saturated is the (MIN_HIGH+1)-th high one.
  assign long_high = lvl && (cnt == CNT_MAX);
endmodule

// File: rtl/rsq_init_timer.sv
// Fixed-length interval counter, reloaded while the sequencer is halted.
module rsq_init_timer #(
  parameter int CYCLES = 10
) (
  input  logic clk,
  input  logic load,
  input  logic run,
  output logic done
);
  localparam int TW = $clog2(CYCLES);
  localparam logic [TW-1:0] LAST = TW'(CYCLES - 1);

  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (load)              cnt <= '0;
    else if (run && !done) cnt <= cnt + 1'b1;
  end

  assign done = (cnt == LAST);
endmodule

// File: rtl/core_start_sequencer.sv
module core_start_sequencer #(
  parameter int          SYNC_STAGES   = 2,
  parameter int          MIN_HIGH_CLKS = 4,
  parameter int          INIT_CLKS     = 10,
  parameter int          ADDR_W        = 20,
  parameter logic [19:0] START_ADDR    = 20'hFFFF0
) (
  input  logic              clk,
  input  logic              rst_pin,
  output logic              core_halt,
  output logic              init_busy,
  output logic              start_pulse,
  output logic [ADDR_W-1:0] start_addr
);
  import rsq_pkg::*;

  seq_state_e state, state_nx;
  logic s_rst;
  logic long_high;
  logic tmr_done;

  rsq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .d   (rst_pin),
    .q   (s_rst)
  );

  rsq_width_qual #(.MIN_HIGH(MIN_HIGH_CLKS)) u_qual (
    .clk       (clk),
    .lvl       (s_rst),
    .long_high (long_high)
  );

  rsq_init_timer #(.CYCLES(INIT_CLKS)) u_tmr (
    .clk  (clk),
    .load (state == ST_HALT),
    .run  (state == ST_INIT),
    .done (tmr_done)
  );

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_RUN:   if (long_high) state_nx = ST_HALT;
      ST_HALT:  if (!s_rst)    state_nx = ST_INIT;
      // A renewed reset outranks completion of the count.
      ST_INIT:  if (s_rst)         state_nx = ST_HALT;
                else if (tmr_done) state_nx = ST_START;
      ST_START: state_nx = long_high ? ST_HALT : ST_RUN;
      default:  state_nx = ST_HALT;
    endcase
  end

  always_ff @(posedge clk) begin
    state <= state_nx;
  end

  assign core_halt   = (state == ST_HALT) || (state == ST_INIT);
  assign init_busy   = (state == ST_INIT);
  assign start_pulse = (state == ST_START);
  assign start_addr  = ADDR_W'(START_ADDR);
endmodule

// File: rtl/core_start_sequencer_chk.sv
module core_start_sequencer_chk #(
  parameter int          INIT_CLKS  = 10,
  parameter int          ADDR_W     = 20,
  parameter logic [19:0] START_ADDR = 20'hFFFF0
) (
  input logic              clk,
  input logic              core_halt,
  input logic              init_busy,
  input logic              start_pulse,
  input logic [ADDR_W-1:0] start_addr
);
  localparam int BW = $clog2(INIT_CLKS + 2);
  localparam logic [BW-1:0] BMAX = BW'(INIT_CLKS + 1);

  // Armed by the first accepted reset; the pin itself is the block's reset.
  logic primed = 1'b0;
  logic [BW-1:0] busy_run = '0;

  always_ff @(posedge clk) begin
    if (core_halt) primed <= 1'b1;
    if (!init_busy)           busy_run <= '0;
    else if (busy_run != BMAX) busy_run <= busy_run + 1'b1;
  end

  // R4
  busy_under_halt_chk: assert property (@(posedge clk) disable iff (!primed)
    init_busy |-> core_halt);

  // R4
  busy_len_chk: assert property (@(posedge clk) disable iff (!primed)
    busy_run <= BW'(INIT_CLKS));

  // R5
  pulse_single_chk: assert property (@(posedge clk) disable iff (!primed)
    start_pulse |=> !start_pulse);

  // R5
  pulse_after_busy_chk: assert property (@(posedge clk) disable iff (!primed)
    start_pulse |-> ($past(init_busy) && !core_halt));

  // R6
  start_addr_chk: assert property (@(posedge clk) disable iff (!primed)
    start_pulse |-> (start_addr == ADDR_W'(START_ADDR)));

  // R3
  halt_release_chk: assert property (@(posedge clk) disable iff (!primed)
    $fell(core_halt) |-> start_pulse);
endmodule

bind core_start_sequencer core_start_sequencer_chk #(
  .INIT_CLKS  (INIT_CLKS),
  .ADDR_W     (ADDR_W),
  .START_ADDR (START_ADDR)
) u_chk (
  .clk         (clk),
  .core_halt   (core_halt),
  .init_busy   (init_busy),
  .start_pulse (start_pulse),
  .start_addr  (start_addr)
);

// File: tb/core_start_sequencer_bench.sv
module core_start_sequencer_bench;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_pin = 1'b1;
  logic        core_halt, init_busy, start_pulse;
  logic [19:0] start_addr;

  int checks = 0;
  int fails  = 0;

  core_start_sequencer u_core_start_sequencer (
    .clk         (clk),
    .rst_pin     (rst_pin),
    .core_halt   (core_halt),
    .init_busy   (init_busy),
    .start_pulse (start_pulse),
    .start_addr  (start_addr)
  );

  // Pulse-width table: [4:1] high length in clocks, [0] expected acceptance.
  localparam logic [4:0] VEC [7] = '{
    {4'd1, 1'b0}, {4'd2, 1'b0}, {4'd3, 1'b0}, {4'd4, 1'b0},
    {4'd5, 1'b1}, {4'd6, 1'b1}, {4'd9, 1'b1}
  };

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic run_all();
    int halt_seen, busy_seen, pulses;

    // Reset state: pin held high from time zero.
    repeat (8) @(negedge clk);
    chk("R3", "halt in reset", int'(core_halt), 1);
    chk("R4", "busy in reset", int'(init_busy), 0);
    chk("R5", "pulse in reset", int'(start_pulse), 0);
    chk("R6", "start address", int'(start_addr), 20'hFFFF0);

    // Fall timing: observe after edges f0..f14.
    rst_pin = 1'b0;
    for (int i = 0; i < 15; i++) begin
      @(negedge clk);
      chk("R4", $sformatf("busy after f%0d", i), int'(init_busy), int'(i >= 2 && i <= 11));
      chk("R4", $sformatf("halt after f%0d", i), int'(core_halt), int'(i <= 11));
      chk("R5", $sformatf("pulse after f%0d", i), int'(start_pulse), int'(i == 12));
      if (start_pulse) chk("R6", "addr at pulse", int'(start_addr), 20'hFFFF0);
    end

    // Width table.
    for (int v = 0; v < 7; v++) begin
      halt_seen = 0; busy_seen = 0; pulses = 0;
      rst_pin = 1'b1;
      repeat (int'(VEC[v][4:1])) begin
        @(negedge clk);
        halt_seen |= int'(core_halt);
      end
      rst_pin = 1'b0;
      repeat (25) begin
        @(negedge clk);
        halt_seen |= int'(core_halt);
        busy_seen |= int'(init_busy);
        pulses += int'(start_pulse);
      end
      chk(VEC[v][0] ? "R1" : "R2", $sformatf("halt seen len %0d", VEC[v][4:1]), halt_seen, int'(VEC[v][0]));
      chk(VEC[v][0] ? "R4" : "R2", $sformatf("busy seen len %0d", VEC[v][4:1]), busy_seen, int'(VEC[v][0]));
      chk(VEC[v][0] ? "R5" : "R2", $sformatf("pulses len %0d", VEC[v][4:1]), pulses, int'(VEC[v][0]));
      chk("R8", $sformatf("running after len %0d", VEC[v][4:1]), int'(core_halt), 0);
    end

    // Exact qualification timing, then a long hold.
    rst_pin = 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk("R1", $sformatf("halt after k%0d", i), int'(core_halt), int'(i >= 6));
    end
    halt_seen = 1;
    repeat (40) begin
      @(negedge clk);
      halt_seen &= int'(core_halt);
    end
    chk("R3", "halt held through long reset", halt_seen, 1);

    // Abort on the last interval edge: pin sampled high at f10 only.
    rst_pin = 1'b0;
    for (int i = 0; i < 28; i++) begin
      @(negedge clk);
      chk("R7", $sformatf("busy after f%0d", i), int'(init_busy),
          int'((i >= 2 && i <= 11) || (i >= 13 && i <= 22)));
      chk("R7", $sformatf("halt after f%0d", i), int'(core_halt), int'(i <= 22));
      chk("R7", $sformatf("pulse after f%0d", i), int'(start_pulse), int'(i == 23));
      if (i == 9)  rst_pin = 1'b1;
      if (i == 10) rst_pin = 1'b0;
    end
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule